// File: doc/BRIEF.md
# Multiplexed Bus Cycle Demultiplexer

This block sits beside an early 8-bit processor that shares one 8-bit bus three ways within each machine cycle. The bus carries the low address byte first, then the upper address bits with a two-bit cycle type, and then the data byte. The processor reports which step it is in on a 3-bit state code and marks the sampling point of each step with a SYNC pulse. The block decodes the state code into eight one-hot step lines. It rebuilds the 14-bit address and the cycle type, and it produces memory read and write strobes for the data step. It also tracks interrupt acknowledge and the halted condition, and it drives a READY line that holds the processor in its wait step for a configurable number of clocks.

There is no valid/ready stream at the edges of the block. The processor sets the pace, and the block only observes it. The one back-pressure path is READY: while READY is low during a data step, the processor enters WAIT. The block keeps its strobe and its latched address unchanged until the processor leaves WAIT.

Top module: `busdemux_top`

## Requirements
- R1: `step_oh` is one-hot, and bit k is set exactly when `st_code` equals k. The codes are: 000 WAIT, 001 T3, 010 T1, 011 STOPPED, 100 T2, 101 T5, 110 T1I, 111 T4.
- R2: On a clock edge with `sync_in` high in step T1 or T1I, `bus_in` is stored into `addr_out[7:0]`.
- R3: On a clock edge with `sync_in` high in step T2, `bus_in[5:0]` is stored into `addr_out[13:8]` and `bus_in[7:6]` into `cyc_type`.
- R4: No capture happens on an edge where `sync_in` is low, or in any step other than T1, T1I and T2. `addr_out` and `cyc_type` keep their values in those cases.
- R5: In step T3 or WAIT, `rd_stb` is high when `cyc_type` is 00 (fetch) or 10 (data read), and `wr_stb` is high when `cyc_type` is 11 (data write). Neither strobe is high when `cyc_type` is 01 (I/O).
- R6: Both strobes are low in every step other than T3 and WAIT, including T4 and T5.
- R7: `intack` rises after a sync-qualified T1I edge and stays high until the next sync-qualified T1 edge.
- R8: `halted` rises after a sync-qualified STOPPED edge and stays high until `intr_in` is seen high, which clears it on the following edge.
- R9: While the processor reports WAIT, the strobe and `addr_out` stay unchanged, even when `sync_in` pulses with new bus data.
- R10: After a sync-qualified T3 edge of a memory cycle (`cyc_type` not 01), `ready_out` is low for exactly WAIT_CYCLES clocks and then high. After an I/O T3, `ready_out` stays high.
- R11: After reset, `addr_out` = 0, `cyc_type` = 00, `intack` = 0, `halted` = 0 and `ready_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_code | input | 3 | Processor state code {S2,S1,S0} |
| sync_in | input | 1 | Step sampling strobe from the processor |
| bus_in | input | 8 | Shared address/data bus as seen by the block |
| intr_in | input | 1 | Interrupt request, clears the halted flag |
| step_oh | output | 8 | One-hot step indication, indexed by state code |
| addr_out | output | 14 | Rebuilt memory address |
| cyc_type | output | 2 | Cycle type captured at T2 |
| rd_stb | output | 1 | Memory read strobe |
| wr_stb | output | 1 | Memory write strobe |
| ready_out | output | 1 | READY to the processor, low inserts wait |
| intack | output | 1 | Interrupt-acknowledge cycle flag |
| halted | output | 1 | Processor is stopped |

## Verification
The bench sweeps all eight state codes and all four cycle types, and uses several address patterns with distinct high and low bytes. A swapped code mapping or a wrong field slice would show up as a misplaced one-hot bit or a corrupted address. It drives T1 and T2 with SYNC low, and WAIT with SYNC pulsing and new bus data. A capture that ignores SYNC qualification would overwrite the address there. It counts READY-low clocks after memory and I/O data steps, so an off-by-one wait or a wait on I/O cycles is caught. It also checks that T4 and T5 never strobe, that the acknowledge flag clears only on a plain T1, and that the halted flag clears only on an interrupt.

// File: rtl/busdemux_pkg.sv
package busdemux_pkg;
  localparam int NSTEP = 8;
  localparam int CODE_W = 3;
  localparam int ADDR_W = 14;
  localparam int BUS_W = 8;

  typedef enum logic [CODE_W-1:0] {
    ST_WAIT = 3'b000,
    ST_T3   = 3'b001,
    ST_T1   = 3'b010,
    ST_STOP = 3'b011,
    ST_T2   = 3'b100,
    ST_T5   = 3'b101,
    ST_T1I  = 3'b110,
    ST_T4   = 3'b111
  } step_code_e;

  localparam logic [1:0] CT_FETCH = 2'b00;
  localparam logic [1:0] CT_READ  = 2'b10;
  localparam logic [1:0] CT_IO    = 2'b01;
  localparam logic [1:0] CT_WRITE = 2'b11;
endpackage

// File: rtl/step_decoder.sv
module step_decoder
  import busdemux_pkg::*;
(
  input  logic [CODE_W-1:0] st_code,
  output logic [NSTEP-1:0]  step_oh
);
  // One output line per code value; the code value is the bit index.
  for (genvar g = 0; g < NSTEP; g++) begin : g_dec
    assign step_oh[g] = (st_code == CODE_W'(g));
  end
endmodule

// File: rtl/bus_capture.sv
module bus_capture
  import busdemux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              intr_in,
  input  logic              is_t1,
  input  logic              is_t1i,
  input  logic              is_t2,
  input  logic              is_stop,
  input  logic              is_wait,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        cyc_type,
  output logic              intack,
  output logic              halted
);
  localparam int HI_W = ADDR_W - BUS_W;

  logic lo_en, hi_en;
  assign lo_en = sync_in & (is_t1 | is_t1i);
  assign hi_en = sync_in & is_t2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out <= '0;
      cyc_type <= CT_FETCH;
    end else begin
      if (lo_en) addr_out[BUS_W-1:0] <= bus_in;
      if (hi_en) begin
        addr_out[ADDR_W-1:BUS_W] <= bus_in[HI_W-1:0];
        cyc_type                 <= bus_in[BUS_W-1:BUS_W-2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intack <= 1'b0;
      halted <= 1'b0;
    end else begin
      if (sync_in && is_t1i)     intack <= 1'b1;
      else if (sync_in && is_t1) intack <= 1'b0;
      if (intr_in)                 halted <= 1'b0;
      else if (sync_in && is_stop) halted <= 1'b1;
    end
  end

  a_r2_lo_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && (is_t1 || is_t1i)) |=> (addr_out[BUS_W-1:0] == $past(bus_in)));
  a_r3_hi_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && is_t2) |=> (addr_out[ADDR_W-1:BUS_W] == $past(bus_in[HI_W-1:0])));
  a_r9_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    is_wait |=> $stable(addr_out) && $stable(cyc_type));
  a_r8_intr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    intr_in |=> !halted);
  a_r7_ack_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && is_t1i) |=> intack);
endmodule

// File: rtl/strobe_wait.sv
module strobe_wait
  import busdemux_pkg::*;
#(
  parameter int WAIT_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       is_t3,
  input  logic       is_wait,
  input  logic       is_t4,
  input  logic       is_t5,
  input  logic [1:0] cyc_type,
  output logic       rd_stb,
  output logic       wr_stb,
  output logic       ready_out
);
  localparam int CW = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);

  logic data_step, mem_cycle;
  assign data_step = is_t3 | is_wait;
  assign mem_cycle = (cyc_type != CT_IO);

  assign rd_stb = data_step & ~cyc_type[0];
  assign wr_stb = data_step & (cyc_type == CT_WRITE);

  logic [CW-1:0] wcnt;

  if (WAIT_CYCLES > 0) begin : g_wait
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            wcnt <= '0;
      else if (sync_in && is_t3 && mem_cycle) wcnt <= CW'(WAIT_CYCLES);
      else if (wcnt != '0)                   wcnt <= wcnt - 1'b1;
    end
  end else begin : g_nowait
    assign wcnt = '0;
  end

  assign ready_out = (wcnt == '0);

  a_r6_no_strobe_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (is_t4 || is_t5) |-> (!rd_stb && !wr_stb));
  a_r10_wait_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && is_t3 && mem_cycle && (WAIT_CYCLES > 0)) |=> !ready_out);
  a_r10_io_nowait: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && is_t3 && !mem_cycle && ready_out) |=> ready_out);
  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
endmodule

// File: rtl/busdemux_top.sv
module busdemux_top
  import busdemux_pkg::*;
#(
  parameter int WAIT_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  st_code,
  input  logic        sync_in,
  input  logic [7:0]  bus_in,
  input  logic        intr_in,
  output logic [7:0]  step_oh,
  output logic [13:0] addr_out,
  output logic [1:0]  cyc_type,
  output logic        rd_stb,
  output logic        wr_stb,
  output logic        ready_out,
  output logic        intack,
  output logic        halted
);
  step_decoder u_dec (
    .st_code (st_code),
    .step_oh (step_oh)
  );

  bus_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .bus_in   (bus_in),
    .intr_in  (intr_in),
    .is_t1    (step_oh[int'(ST_T1)]),
    .is_t1i   (step_oh[int'(ST_T1I)]),
    .is_t2    (step_oh[int'(ST_T2)]),
    .is_stop  (step_oh[int'(ST_STOP)]),
    .is_wait  (step_oh[int'(ST_WAIT)]),
    .addr_out (addr_out),
    .cyc_type (cyc_type),
    .intack   (intack),
    .halted   (halted)
  );

  strobe_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_stb (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .is_t3     (step_oh[int'(ST_T3)]),
    .is_wait   (step_oh[int'(ST_WAIT)]),
    .is_t4     (step_oh[int'(ST_T4)]),
    .is_t5     (step_oh[int'(ST_T5)]),
    .cyc_type  (cyc_type),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .ready_out (ready_out)
  );

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(step_oh));
  a_r6_no_strobe_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (step_oh[int'(ST_T1)] || step_oh[int'(ST_T2)] || step_oh[int'(ST_STOP)])
      |-> (!rd_stb && !wr_stb));
endmodule

// File: tb/tb_busdemux_top.sv
module tb_busdemux_top;
  localparam int NW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  st_code = 3'b111;
  logic        sync_in = 1'b0;
  logic [7:0]  bus_in = 8'h00;
  logic        intr_in = 1'b0;
  logic [7:0]  step_oh;
  logic [13:0] addr_out;
  logic [1:0]  cyc_type;
  logic        rd_stb, wr_stb, ready_out, intack, halted;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  busdemux_top #(.WAIT_CYCLES(NW)) dut (
    .clk(clk), .rst_n(rst_n), .st_code(st_code), .sync_in(sync_in),
    .bus_in(bus_in), .intr_in(intr_in), .step_oh(step_oh),
    .addr_out(addr_out), .cyc_type(cyc_type), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .ready_out(ready_out), .intack(intack), .halted(halted)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One sync-qualified step: bus valid for one edge, then sync drops.
  task automatic step(input logic [2:0] code, input logic [7:0] data);
    @(negedge clk);
    st_code = code; bus_in = data; sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [13:0] exp_addr;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 addr", 32'(addr_out), 0);
    chk("R11 cyc", 32'(cyc_type), 0);
    chk("R11 flags", {intack, halted, ready_out}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 decoder sweep
    for (int c = 0; c < 8; c++) begin
      st_code = 3'(c);
      #1;
      chk("R1 onehot", 32'(step_oh), 32'(1) << c);
    end

    // Full cycles over all cycle types and several address patterns
    for (int ct = 0; ct < 4; ct++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] lo;
        logic [5:0] hi;
        logic memc;
        lo = 8'(8'h5A ^ (p * 8'h33) ^ ct);
        hi = 6'(6'h2C ^ (p * 6'h15) ^ (ct << 2));
        exp_addr = {hi, lo};
        memc = (ct != 1);
        step(3'b010, lo);                    // T1
        chk("R6 T1 nostrobe", {rd_stb, wr_stb}, 2'b00);
        step(3'b100, {2'(ct), hi});          // T2
        chk("R2 R3 addr", 32'(addr_out), 32'(exp_addr));
        chk("R3 cyc", 32'(cyc_type), 32'(ct));
        // R4: T2 and T1 without sync do not capture
        @(negedge clk); st_code = 3'b010; bus_in = ~lo;
        @(negedge clk); st_code = 3'b100; bus_in = ~bus_in;
        @(negedge clk);
        chk("R4 nosync", 32'(addr_out), 32'(exp_addr));
        step(3'b001, 8'hC3);                 // T3
        chk("R5 rd", 32'(rd_stb), 32'(ct[0] == 1'b0));
        chk("R5 wr", 32'(wr_stb), 32'(ct == 3));
        for (int i = 0; i < NW; i++) begin
          chk("R10 ready low", 32'(ready_out), 32'(!memc));
          @(negedge clk);
        end
        chk("R10 ready back", 32'(ready_out), 1);
        // R9: WAIT with sync and new data keeps address and strobe
        step(3'b000, 8'hFF);
        step(3'b000, 8'h00);
        chk("R9 addr hold", 32'(addr_out), 32'(exp_addr));
        chk("R9 rd hold", 32'(rd_stb), 32'(ct[0] == 1'b0));
        chk("R9 wr hold", 32'(wr_stb), 32'(ct == 3));
        step(3'b111, 8'h11);                 // T4
        chk("R6 T4", {rd_stb, wr_stb}, 2'b00);
        step(3'b101, 8'h22);                 // T5
        chk("R6 T5", {rd_stb, wr_stb}, 2'b00);
        chk("R4 T4T5 nocap", 32'(addr_out), 32'(exp_addr));
      end
    end

    // R7 interrupt acknowledge
    step(3'b110, 8'h9E);
    chk("R7 ack set", 32'(intack), 1);
    chk("R2 T1I lo", 32'(addr_out[7:0]), 32'h9E);
    step(3'b100, 8'h05);
    step(3'b001, 8'h00);
    chk("R7 ack held", 32'(intack), 1);
    step(3'b010, 8'h10);
    chk("R7 ack clear", 32'(intack), 0);

    // R8 halt
    step(3'b011, 8'h00);
    chk("R8 halted set", 32'(halted), 1);
    chk("R6 stop nostrobe", {rd_stb, wr_stb}, 2'b00);
    repeat (5) @(negedge clk);
    chk("R8 halted held", 32'(halted), 1);
    intr_in = 1'b1;
    @(negedge clk);
    intr_in = 1'b0;
    chk("R8 halted clear", 32'(halted), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule